// File: doc/BRIEF.md
# Paged ROM Window Controller

This block lets a bus master reach a ROM that is much larger than the address window the bus sets aside for it. A 512-byte window is cut into two 256-byte halves. Each half is steered onto the ROM by its own byte of a shared 16-bit page register. Bus address bit 8 picks the byte. That byte, shifted right by one, forms the upper ROM address bits. The bit shifted out lands on ROM address bit 8, and bus address bits 7:0 pass through unchanged.

Software loads the two page bytes independently with byte-strobed writes to a fixed register address and can read the whole register back. A second fixed address holds a four-bit display register that drives four indicator outputs directly. A read inside the window produces a registered ROM address and a one-cycle ROM select strobe. Any other access leaves the select low.

Top module: `paged_rom_window`

## Requirements
- R1: During and right after synchronous reset, the page register and the display register are zero, `rom_sel` is low, `rom_addr` is zero and `bus_rdata` is zero.
- R2: A write to the page address with `bus_be` = 2'b01 changes only page bits 7:0, with 2'b10 only bits 15:8, and with 2'b11 both. A read of the page address returns the whole register on `bus_rdata` one cycle after the read.
- R3: A read whose address lies in the window raises `rom_sel` in the cycle after the access, with `rom_addr[7:0]` equal to the bus address bits 7:0.
- R4: When bus address bit 8 of a window read is 0, `rom_addr[15:9]` is the low page byte shifted right by one and `rom_addr[8]` is bit 0 of the low page byte.
- R5: When bus address bit 8 of a window read is 1, the same mapping uses the high page byte, and the low byte has no effect.
- R6: Accesses outside the window, accesses to the register addresses, and idle cycles leave `rom_sel` low and `rom_addr` at zero in the following cycle.
- R7: A write to the display address with `bus_be[0]` set loads `bus_wdata[3:0]` into the display register, which drives `disp_led` from the next cycle. A write with `bus_be[0]` clear leaves it unchanged. A read of the display address returns it in `bus_rdata[3:0]` with the upper bits zero.
- R8: A write inside the window raises no `rom_sel` and changes neither the page register nor the display register.
- R9: A page write takes effect for a window read in the very next cycle.
- R10: Reads of the window or of any address that is neither register return zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte strobes: bit 0 low byte, bit 1 high byte |
| bus_rdata | output | 16 | Registered read data |
| rom_addr | output | 16 | Registered ROM address |
| rom_sel | output | 1 | ROM select, high for one cycle per window read |
| disp_led | output | 4 | Display register outputs |

## Verification
The ROM address, the select strobe and the read data are all registered, so each is due one rising edge after the access that causes it. Page and display writes land on that same edge and become visible to the next access. The bench drives each access after a falling edge and reads the results at the next falling edge, which is exactly one registered stage later. A behavioural model that advances on the same rising edge supplies the expected value for every output on every cycle. Directed checks then confirm the back-to-back write-then-read case and the byte-strobe cases with fixed expected values.

// File: rtl/prw_pkg.sv
package prw_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int OFFS_W  = BYTE_W;          // low address bits passed through
    localparam int HALF_B  = OFFS_W;          // bus bit choosing the page byte
    localparam int WIN_LSB = OFFS_W + 1;      // first bit above the window
    localparam int ROM_W   = BYTE_W + OFFS_W;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WIN_LO,
        ACC_WIN_HI,
        ACC_PAGE,
        ACC_DISP,
        ACC_OTHER
    } acc_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } page_t;

    // Upper part: selected byte shifted right; the shifted-out bit feeds
    // the bit just above the pass-through offset.
    function automatic logic [ROM_W-1:0] map_rom(
        input logic [BYTE_W-1:0] pg,
        input logic [OFFS_W-1:0] offs
    );
        logic [BYTE_W-2:0] upper;
        logic              mid;
        upper = pg >> 1;
        mid   = pg[0];
        return {upper, mid, offs};
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(
        input page_t pg,
        input logic  upper_half
    );
        return upper_half ? pg.hi : pg.lo;
    endfunction

endpackage

// File: rtl/prw_decode.sv
module prw_decode
    import prw_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] WIN_BASE  = 16'hE000,
    parameter logic [15:0] PAGE_ADDR = 16'hF000,
    parameter logic [15:0] DISP_ADDR = 16'hF002
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    localparam int TAG_W = ADDR_W - WIN_LSB;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LSB];

    logic in_win;
    logic is_page;
    logic is_disp;

    always_comb begin
        in_win  = (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
        is_page = (addr == PAGE_ADDR[ADDR_W-1:0]);
        is_disp = (addr == DISP_ADDR[ADDR_W-1:0]);
    end

    always_comb begin
        kind = ACC_IDLE;
        if (valid) begin
            if (is_page)
                kind = ACC_PAGE;
            else if (is_disp)
                kind = ACC_DISP;
            else if (in_win)
                kind = addr[HALF_B] ? ACC_WIN_HI : ACC_WIN_LO;
            else
                kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/prw_page_reg.sv
module prw_page_reg
    import prw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [WORD_W-1:0] wdata,
    output page_t             page
);

    page_t page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else begin
            if (we_lo)
                page_q.lo <= wdata[BYTE_W-1:0];
            if (we_hi)
                page_q.hi <= wdata[WORD_W-1:BYTE_W];
        end
    end

    assign page = page_q;

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_lo |=> $stable(page_q.lo));

    // R2
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_hi |=> $stable(page_q.hi));

endmodule

// File: rtl/prw_disp_reg.sv
module prw_disp_reg #(
    parameter int DISP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DISP_W-1:0] wdata,
    output logic [DISP_W-1:0] lamps
);

    logic [DISP_W-1:0] lamps_q;

    always_ff @(posedge clk) begin
        if (rst)
            lamps_q <= '0;
        else if (we)
            lamps_q <= wdata;
    end

    assign lamps = lamps_q;

    // R7
    disp_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (lamps_q == $past(wdata)));

endmodule

// File: rtl/prw_rom_map.sv
module prw_rom_map
    import prw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic              upper_half,
    input  logic [OFFS_W-1:0] offs,
    input  page_t             page,
    output logic [ROM_W-1:0]  rom_addr,
    output logic              rom_sel
);

    logic [ROM_W-1:0] addr_d;
    logic [ROM_W-1:0] addr_q;
    logic             sel_q;

    always_comb begin
        addr_d = '0;
        if (hit)
            addr_d = map_rom(pick_byte(page, upper_half), offs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            sel_q  <= 1'b0;
        end else begin
            addr_q <= addr_d;
            sel_q  <= hit;
        end
    end

    assign rom_addr = addr_q;
    assign rom_sel  = sel_q;

    // R3
    sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (sel_q && addr_q[OFFS_W-1:0] == $past(offs)));

    // R6
    no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (!sel_q && addr_q == '0));

    // R4
    low_page_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !upper_half) |=> (addr_q[ROM_W-1:OFFS_W] == $past(page.lo)));

    // R5
    high_page_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && upper_half) |=> (addr_q[ROM_W-1:OFFS_W] == $past(page.hi)));

endmodule

// File: rtl/paged_rom_window.sv
module paged_rom_window
    import prw_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DISP_W    = 4,
    parameter logic [15:0] WIN_BASE  = 16'hE000,
    parameter logic [15:0] PAGE_ADDR = 16'hF000,
    parameter logic [15:0] DISP_ADDR = 16'hF002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [1:0]        bus_be,
    output logic [15:0]       bus_rdata,
    output logic [15:0]       rom_addr,
    output logic              rom_sel,
    output logic [DISP_W-1:0] disp_led
);

    acc_kind_e         kind;
    page_t             page;
    logic              page_we_lo;
    logic              page_we_hi;
    logic              disp_we;
    logic              rom_hit;
    logic [DISP_W-1:0] lamps;
    logic [15:0]       rd_d;
    logic [15:0]       rd_q;

    prw_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .PAGE_ADDR(PAGE_ADDR),
        .DISP_ADDR(DISP_ADDR)
    ) u_dec (
        .valid(bus_valid),
        .addr (bus_addr),
        .kind (kind)
    );

    always_comb begin
        page_we_lo = bus_wr && (kind == ACC_PAGE) && bus_be[0];
        page_we_hi = bus_wr && (kind == ACC_PAGE) && bus_be[1];
        disp_we    = bus_wr && (kind == ACC_DISP) && bus_be[0];
        rom_hit    = !bus_wr && ((kind == ACC_WIN_LO) || (kind == ACC_WIN_HI));
    end

    prw_page_reg u_page (
        .clk  (clk),
        .rst  (rst),
        .we_lo(page_we_lo),
        .we_hi(page_we_hi),
        .wdata(bus_wdata),
        .page (page)
    );

    prw_disp_reg #(
        .DISP_W(DISP_W)
    ) u_disp (
        .clk  (clk),
        .rst  (rst),
        .we   (disp_we),
        .wdata(bus_wdata[DISP_W-1:0]),
        .lamps(lamps)
    );

    prw_rom_map u_map (
        .clk       (clk),
        .rst       (rst),
        .hit       (rom_hit),
        .upper_half(kind == ACC_WIN_HI),
        .offs      (bus_addr[OFFS_W-1:0]),
        .page      (page),
        .rom_addr  (rom_addr),
        .rom_sel   (rom_sel)
    );

    // Readback: registers only; window and unmapped reads return zero.
    always_comb begin
        rd_d = '0;
        if (!bus_wr) begin
            case (kind)
                ACC_PAGE: rd_d = page;
                ACC_DISP: rd_d[DISP_W-1:0] = lamps;
                default:  rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;
    assign disp_led  = lamps;

    // R8
    win_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_wr && (kind == ACC_WIN_LO || kind == ACC_WIN_HI))
        |=> (!rom_sel && $stable(page) && $stable(disp_led)));

    // R10
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_wr && kind != ACC_PAGE && kind != ACC_DISP)
        |=> (bus_rdata == 16'h0000));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rom_sel && rom_addr == '0 && bus_rdata == '0 && disp_led == '0));

endmodule

// File: tb/sim_paged_rom_window.sv
`timescale 1ns/1ps
module sim_paged_rom_window;

    localparam logic [15:0] WIN  = 16'hE000;
    localparam logic [15:0] PGA  = 16'hF000;
    localparam logic [15:0] DSA  = 16'hF002;
    localparam int          WDOG = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic [15:0] rom_addr;
    logic        rom_sel;
    logic [3:0]  disp_led;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    paged_rom_window u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .rom_addr(rom_addr), .rom_sel(rom_sel),
        .disp_led(disp_led)
    );

    // Behavioural reference model
    int m_page, m_disp, m_raddr, m_rd;
    bit m_sel;

    always @(posedge clk) begin
        int a, byt;
        bit inwin, isreg;
        a     = int'(bus_addr);
        isreg = (a == int'(PGA)) || (a == int'(DSA));
        inwin = !isreg && (a / 512 == int'(WIN) / 512);
        if (rst) begin
            m_page = 0; m_disp = 0; m_sel = 0; m_raddr = 0; m_rd = 0;
        end else begin
            m_sel = 0; m_raddr = 0; m_rd = 0;
            if (bus_valid && !bus_wr) begin
                if (inwin) begin
                    byt     = ((a / 256) % 2 == 1) ? (m_page / 256) : (m_page % 256);
                    m_sel   = 1;
                    m_raddr = (byt / 2) * 512 + (byt % 2) * 256 + (a % 256);
                end
                if (a == int'(PGA)) m_rd = m_page;
                if (a == int'(DSA)) m_rd = m_disp;
            end
            if (bus_valid && bus_wr) begin
                if (a == int'(PGA)) begin
                    if (bus_be[0]) m_page = (m_page / 256) * 256 + int'(bus_wdata) % 256;
                    if (bus_be[1]) m_page = (int'(bus_wdata) / 256) * 256 + m_page % 256;
                end
                if (a == int'(DSA) && bus_be[0]) m_disp = int'(bus_wdata) % 16;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            chk(rom_sel == m_sel, "R3/R6 rom_sel", int'(rom_sel), m_sel);
            chk(int'(rom_addr) == m_raddr, "R4/R5 rom_addr", int'(rom_addr), m_raddr);
            chk(int'(bus_rdata) == m_rd, "R2/R7/R10 rdata", int'(bus_rdata), m_rd);
            chk(int'(disp_led) == m_disp, "R7 disp_led", int'(disp_led), m_disp);
        end
    end

    // One access; returns after the falling edge that follows its sampling edge
    task automatic acc(input bit v, input bit w, input logic [15:0] a,
                       input logic [15:0] d, input logic [1:0] be);
        bus_valid = v; bus_wr = w; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state
        chk(rom_sel == 0 && rom_addr == 0 && bus_rdata == 0 && disp_led == 0,
            "R1 reset outputs", int'(rom_addr), 0);
        rst = 1'b0;
        acc(1, 0, PGA, 0, 2'b11);
        chk(bus_rdata == 16'h0000, "R1 page after reset", int'(bus_rdata), 0);

        // R2: byte-strobed page writes
        acc(1, 1, PGA, 16'h7735, 2'b01);
        acc(1, 0, PGA, 0, 2'b11);
        chk(bus_rdata == 16'h0035, "R2 low strobe", int'(bus_rdata), 16'h0035);
        acc(1, 1, PGA, 16'hA2FF, 2'b10);
        acc(1, 0, PGA, 0, 2'b11);
        chk(bus_rdata == 16'hA235, "R2 high strobe", int'(bus_rdata), 16'hA235);

        // R3/R4: lower half uses low byte 0x35
        acc(1, 0, WIN + 16'h0012, 0, 2'b11);
        chk(rom_sel && rom_addr == 16'h3512, "R4 lower half", int'(rom_addr), 16'h3512);
        // R5: upper half uses high byte 0xA2
        acc(1, 0, WIN + 16'h01FE, 0, 2'b11);
        chk(rom_sel && rom_addr == 16'hA2FE, "R5 upper half", int'(rom_addr), 16'hA2FE);
        chk(bus_rdata == 16'h0000, "R10 window read data", int'(bus_rdata), 0);

        // R9: write both bytes then window read at once
        acc(1, 1, PGA, 16'h0F81, 2'b11);
        acc(1, 0, WIN + 16'h0100, 0, 2'b11);
        chk(rom_sel && rom_addr == 16'h0F00, "R9 next-cycle page", int'(rom_addr), 16'h0F00);
        acc(1, 0, WIN + 16'h00C3, 0, 2'b11);
        chk(rom_sel && rom_addr == 16'h81C3, "R9 low byte odd", int'(rom_addr), 16'h81C3);

        // R8: write inside window has no effect
        acc(1, 1, WIN + 16'h0010, 16'hFFFF, 2'b11);
        chk(!rom_sel, "R8 no select on write", int'(rom_sel), 0);
        acc(1, 0, PGA, 0, 2'b11);
        chk(bus_rdata == 16'h0F81, "R8 page untouched", int'(bus_rdata), 16'h0F81);

        // R6: outside window and register accesses
        acc(1, 0, 16'h1234, 0, 2'b11);
        chk(!rom_sel && rom_addr == 0, "R6 outside", int'(rom_addr), 0);
        chk(bus_rdata == 0, "R10 unmapped read", int'(bus_rdata), 0);
        acc(1, 0, WIN - 16'h0001, 0, 2'b11);
        chk(!rom_sel, "R6 just below window", int'(rom_sel), 0);
        acc(1, 0, WIN + 16'h0200, 0, 2'b11);
        chk(!rom_sel, "R6 just above window", int'(rom_sel), 0);
        acc(0, 0, WIN, 0, 2'b11);
        chk(!rom_sel, "R6 idle", int'(rom_sel), 0);

        // R7: display register
        acc(1, 1, DSA, 16'hFFF9, 2'b01);
        chk(disp_led == 4'h9, "R7 load", int'(disp_led), 9);
        acc(1, 1, DSA, 16'h0006, 2'b10);
        chk(disp_led == 4'h9, "R7 high-only ignored", int'(disp_led), 9);
        acc(1, 0, DSA, 0, 2'b11);
        chk(bus_rdata == 16'h0009, "R7 readback", int'(bus_rdata), 9);

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0, 1: a = WIN + 16'($urandom_range(0, 511));
                2:    a = PGA;
                3:    a = DSA;
                4:    a = 16'($urandom);
                default: a = WIN + 16'($urandom_range(0, 1023));
            endcase
            acc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), a,
                16'($urandom), 2'($urandom_range(0, 3)));
        end

        // R1: reset mid-run
        acc(1, 1, PGA, 16'h5A5A, 2'b11);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc(1, 0, PGA, 0, 2'b11);
        chk(bus_rdata == 0 && disp_led == 0, "R1 mid-run reset", int'(bus_rdata), 0);

        finish_run();
    end

endmodule